// File: doc/BRIEF.md
# Bridge Error Capture and NMI Request

This block holds the error-reporting and control word of a PCI-to-ISA bridge. Two error inputs from the PCI side, a system-error pulse and a parity-error pulse, are captured into sticky status flags. Each flag has its own enable. When an enabled flag is set, the block drives a non-maskable interrupt request. Software reads the word to find the cause, then writes a one to a flag to clear it.

The same 32-bit word also stores a few plain bridge controls: retry enable, lock input enable, positive decode enable, subtractive decode disable, bus staggering enable and a 3-bit system configuration setting. The block drives these controls out to the rest of the bridge. The word is reached through a single-cycle register port with byte-lane strobes. The read data always shows the current contents of the word.

Top module: `brg_err_nmi`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `cfg_rdata` reads 0, `nmi_req` is low and every control output is 0.
- R2: A high `serr_evt` at a clock edge sets bit 7 of the word. The bit stays set on later cycles with no event.
- R3: A high `perr_evt` at a clock edge sets bit 6 of the word. The bit stays set on later cycles with no event.
- R4: A write with lane 0 enabled and a one in bit 7 (or bit 6) clears that flag at the clock edge. A zero written there leaves the flag unchanged. A write can never set a flag.
- R5: If an error event and a write-one-to-clear of the same flag happen in the same cycle, the flag stays set.
- R6: `nmi_req` is high exactly when (bit 7 and bit 5 are both set) or (bit 6 and bit 4 are both set). Bit 5 enables system-error requests and bit 4 enables parity-error requests. The request stays high until the flag or its enable is cleared.
- R7: The following bits are plain read/write storage, and each one drives its output: bits 2..0 drive `sys_cfg`, bit 8 drives `lock_in_en`, bit 9 drives `retry_en`, bit 12 drives `sub_dec_dis`, bit 13 drives `pos_dec_en` and bit 14 drives `stagger_en`.
- R8: Bits 31..15, 11..10 and 3 always read 0, whatever value is written to them.
- R9: `cfg_be[n]` enables byte lane n (bits 8n+7..8n). A write leaves a disabled lane untouched, and that includes the clear action on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the word |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current word contents |
| serr_evt | input | 1 | System-error event pulse |
| perr_evt | input | 1 | Parity-error event pulse |
| nmi_req | output | 1 | Non-maskable interrupt request |
| retry_en | output | 1 | Retry enable control |
| lock_in_en | output | 1 | Lock input enable control |
| pos_dec_en | output | 1 | Positive decode enable control |
| sub_dec_dis | output | 1 | Subtractive decode disable control |
| stagger_en | output | 1 | Bus staggering enable control |
| sys_cfg | output | 3 | System configuration setting |

## Verification
The bench fires an error event in the same cycle that software clears the same flag. A design that gives the clear priority would lose that error and read the flag as 0. It writes all ones with every lane enabled. A design without reserved masking would read back bits it should drop, and a design that treats the flags as plain storage would set a flag from the write alone. It writes ones to the flag byte while lane 0 is disabled. A design that ignores the strobes would clear a flag it must keep. It also toggles each enable while a flag is already set. A design that latches the request instead of forming it from the flag and enable would keep `nmi_req` high after the enable is cleared.

// File: rtl/brg_err_nmi.sv
module brg_err_nmi (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        serr_evt,
  input  logic        perr_evt,
  output logic        nmi_req,
  output logic        retry_en,
  output logic        lock_in_en,
  output logic        pos_dec_en,
  output logic        sub_dec_dis,
  output logic        stagger_en,
  output logic [2:0]  sys_cfg
);
  localparam int B_SERR_F  = 7;
  localparam int B_PERR_F  = 6;
  localparam int B_SERR_EN = 5;
  localparam int B_PERR_EN = 4;
  localparam int B_LOCK    = 8;
  localparam int B_RETRY   = 9;
  localparam int B_SUBDIS  = 12;
  localparam int B_POSDEC  = 13;
  localparam int B_STAG    = 14;

  logic serr_f, perr_f, serr_en, perr_en;
  logic lane0, lane1;
  logic clr_serr, clr_perr;

  assign lane0    = cfg_we & cfg_be[0];
  assign lane1    = cfg_we & cfg_be[1];
  assign clr_serr = lane0 & cfg_wdata[B_SERR_F];
  assign clr_perr = lane0 & cfg_wdata[B_PERR_F];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_f <= 1'b0;
      perr_f <= 1'b0;
    end else begin
      serr_f <= serr_evt | (serr_f & ~clr_serr);
      perr_f <= perr_evt | (perr_f & ~clr_perr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_en <= 1'b0;
      perr_en <= 1'b0;
      sys_cfg <= 3'd0;
    end else if (lane0) begin
      serr_en <= cfg_wdata[B_SERR_EN];
      perr_en <= cfg_wdata[B_PERR_EN];
      sys_cfg <= cfg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_in_en  <= 1'b0;
      retry_en    <= 1'b0;
      sub_dec_dis <= 1'b0;
      pos_dec_en  <= 1'b0;
      stagger_en  <= 1'b0;
    end else if (lane1) begin
      lock_in_en  <= cfg_wdata[B_LOCK];
      retry_en    <= cfg_wdata[B_RETRY];
      sub_dec_dis <= cfg_wdata[B_SUBDIS];
      pos_dec_en  <= cfg_wdata[B_POSDEC];
      stagger_en  <= cfg_wdata[B_STAG];
    end
  end

  assign nmi_req = (serr_f & serr_en) | (perr_f & perr_en);

  always_comb begin
    cfg_rdata            = '0;
    cfg_rdata[2:0]       = sys_cfg;
    cfg_rdata[B_PERR_EN] = perr_en;
    cfg_rdata[B_SERR_EN] = serr_en;
    cfg_rdata[B_PERR_F]  = perr_f;
    cfg_rdata[B_SERR_F]  = serr_f;
    cfg_rdata[B_LOCK]    = lock_in_en;
    cfg_rdata[B_RETRY]   = retry_en;
    cfg_rdata[B_SUBDIS]  = sub_dec_dis;
    cfg_rdata[B_POSDEC]  = pos_dec_en;
    cfg_rdata[B_STAG]    = stagger_en;
  end
endmodule

// File: rtl/brg_err_nmi_chk.sv
module brg_err_nmi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        serr_evt,
  input logic        perr_evt,
  input logic        nmi_req
);
  assert_serr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serr_evt |=> cfg_rdata[7]);

  assert_perr_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> cfg_rdata[6]);

  assert_serr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && !(cfg_we && cfg_be[0] && cfg_wdata[7])) |=> cfg_rdata[7]);

  assert_serr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be[0] && cfg_wdata[7] && !serr_evt) |=> !cfg_rdata[7]);

  assert_perr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be[0] && cfg_wdata[6] && !perr_evt) |=> !cfg_rdata[6]);

  assert_nmi_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (cfg_rdata[7] || cfg_rdata[6]));

  assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be[1]) |=> (cfg_rdata[14:12] == $past(cfg_wdata[14:12])));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (cfg_rdata[31:15] == 17'd0 && cfg_rdata[11:10] == 2'd0 && !cfg_rdata[3]));

  assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_be[1]) |=> $stable(cfg_rdata[15:8]));
endmodule

bind brg_err_nmi brg_err_nmi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .serr_evt(serr_evt),
  .perr_evt(perr_evt), .nmi_req(nmi_req)
);

// File: tb/brg_err_nmi_test.sv
`timescale 1ns/1ps
module brg_err_nmi_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        serr_evt = 1'b0;
  logic        perr_evt = 1'b0;
  logic        nmi_req;
  logic        retry_en, lock_in_en, pos_dec_en, sub_dec_dis, stagger_en;
  logic [2:0]  sys_cfg;

  typedef struct {
    logic [31:0] rd;
    logic        nmi;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #4 clk = ~clk;

  brg_err_nmi uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .serr_evt(serr_evt),
    .perr_evt(perr_evt), .nmi_req(nmi_req), .retry_en(retry_en),
    .lock_in_en(lock_in_en), .pos_dec_en(pos_dec_en),
    .sub_dec_dis(sub_dec_dis), .stagger_en(stagger_en), .sys_cfg(sys_cfg)
  );

  task automatic check(input exp_t e);
    logic [7:0] outs, eouts;
    outs  = {stagger_en, pos_dec_en, sub_dec_dis, retry_en, lock_in_en, sys_cfg};
    eouts = {e.rd[14], e.rd[13], e.rd[12], e.rd[9], e.rd[8], e.rd[2:0]};
    n_vec++;
    if (cfg_rdata !== e.rd || nmi_req !== e.nmi || outs !== eouts) begin
      n_bad++;
      $display("FAIL %s: rdata=%h nmi=%b outs=%h expected rdata=%h nmi=%b outs=%h",
               e.tag, cfg_rdata, nmi_req, outs, e.rd, e.nmi, eouts);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) check(sb_q.pop_front());
    end
  end

  task automatic step(input logic we, input logic [3:0] be, input logic [31:0] d,
                      input logic se, input logic pe,
                      input logic [31:0] erd, input logic enmi, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_be = be; cfg_wdata = d; serr_evt = se; perr_evt = pe;
    e.rd = erd; e.nmi = enmi; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic [31:0] erd, input logic enmi, input string tag);
    step(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, erd, enmi, tag);
  endtask

  task automatic drain;
    @(negedge clk);
    cfg_we = 0; serr_evt = 0; perr_evt = 0;
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_vec++;
    if (cfg_rdata !== 32'h0 || nmi_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: rdata=%h nmi=%b expected 0 0", cfg_rdata, nmi_req);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(32'h0000_0000, 0, "R1 after reset");
    step(0, 4'h0, 32'h0, 1, 0, 32'h0000_0080, 0, "R2 serr capture, R6 masked");
    idle(32'h0000_0080, 0, "R2 sticky");
    step(0, 4'h0, 32'h0, 0, 1, 32'h0000_00C0, 0, "R3 perr capture");
    step(1, 4'hF, 32'h0, 0, 0, 32'h0000_00C0, 0, "R4 zero write keeps flags");
    step(1, 4'h1, 32'h20, 0, 0, 32'h0000_00E0, 1, "R6 serr enable");
    step(1, 4'h1, 32'hA0, 0, 0, 32'h0000_0060, 0, "R4 clear serr only");
    step(1, 4'h1, 32'h30, 0, 0, 32'h0000_0070, 1, "R6 perr enable");
    step(1, 4'hE, 32'hFFFF_FFC0, 0, 0, 32'h0000_7370, 1, "R9 lane0 masked, R7 R8");
    step(1, 4'h1, 32'h70, 0, 1, 32'h0000_7370, 1, "R5 event beats clear");
    step(1, 4'h1, 32'h70, 0, 0, 32'h0000_7330, 0, "R4 clear perr");
    step(1, 4'hF, 32'hFFFF_FFFF, 1, 0, 32'h0000_73B7, 1, "R5 R8 all ones write");
    step(1, 4'h2, 32'h0, 0, 0, 32'h0000_00B7, 1, "R7 clear ctrl byte");
    step(1, 4'h1, 32'h07, 0, 0, 32'h0000_0087, 0, "R6 enable off masks");
    step(1, 4'h1, 32'h05, 0, 0, 32'h0000_0085, 0, "R7 sys cfg");
    step(1, 4'h1, 32'h45, 0, 0, 32'h0000_0085, 0, "R4 write cannot set perr");
    drain();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(32'h0000_0000, 0, "R1 reset clears flags");
    step(1, 4'h1, 32'h30, 0, 0, 32'h0000_0030, 0, "R6 both enabled no flag");
    step(0, 4'h0, 32'h0, 1, 1, 32'h0000_00F0, 1, "R2 R3 both events");
    step(1, 4'h1, 32'hB0, 0, 0, 32'h0000_0070, 1, "R6 perr still requests");
    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule